// File: doc/BRIEF.md
# Receive Buffer Ring Controller

This block is the device-side keeper of a circular ring of fixed-size receive buffers that live in system memory. The driver programs where the ring starts (a byte address) and how many buffer slots it has. It then hands empty buffers to the hardware by writing a new tail index. Writing the tail index is a doorbell: it has a side effect on the block, not only a stored value. Software reads the head index to see how far the hardware has filled. Buffers from head up to, but not including, tail belong to the hardware. The ring is exhausted when head equals tail.

An incoming word stream with a valid flag and a last-word flag is written, one word per beat, through a memory write port into the buffer at the head slot. The write address is the ring base plus the head index times the buffer stride plus the word offset. When a packet ends, the head steps forward and wraps back to slot 0 at the programmed slot count. A sticky completion flag is also set, and it drives the interrupt line when enabled. A packet that starts while the hardware owns no buffer is discarded as a whole and counted in a saturating counter. Words beyond the buffer size are discarded, but the buffer is still completed.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset the head index, tail index, completion flag and drop count read 0, irq is 0 and mem_we is 0.
- R2: A packet whose first beat arrives while head equals tail causes no memory write and adds 1 to the drop count, which stops at its all-ones value.
- R3: An accepted beat appears on mem_we/mem_addr/mem_wdata one clock later, at address base + head*BUF_WORDS*(DATA_W/8) + offset*(DATA_W/8), where the offset counts the beats of the packet from 0.
- R4: Beats of a packet at offsets BUF_WORDS and above are not written, and the buffer still completes on the last beat.
- R5: On the last beat of an accepted packet the head becomes head+1, or 0 when head+1 is at least the slot count; a register write to the head offset has no effect.
- R6: A register write to the tail offset sets the tail index, and the hardware then owns the slots from head up to that tail.
- R7: Completion flag (bit 0 at offset 4) is set by every buffer completion, stays set until a write with bit 0 = 1 to offset 4 clears it, and a write with bit 0 = 0 leaves it.
- R8: irq equals the completion flag ANDed with the enable bit (bit 0 at offset 5).
- R9: Register offsets: 0 ring base address, 1 slot count, 2 head index (read only), 3 tail index, 4 completion flag, 5 interrupt enable, 6 drop count (read only); offset 7 reads 0.
- R10: Once a packet is dropped, none of its later beats is written, even if a doorbell frees buffers before its last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for reg_addr, combinational |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Input beat data |
| in_last | input | 1 | Beat is the last one of its packet |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
Directed packets first cover three cases. One packet arrives while the ring is exhausted. Short packets fill buffers, so the address arithmetic is seen across slots. An over-long packet shows that truncation still completes the buffer. A packet that is dropped while a doorbell arrives part way through shows that the drop decision is fixed at the first beat. It also shows that this decision is separate from the per-beat ownership check. Random phases then mix packet lengths on both sides of the buffer size, doorbells to arbitrary slots, enable toggles and status clears. These expose wrap errors at the slot count and mix-ups between the head/tail compare and the sticky flag. A long run of packets against an exhausted ring checks that the drop counter saturates.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_FILL = 2'd1,
        PK_DROP = 2'd2
    } pk_state_e;

    localparam logic [2:0] OFS_BASE = 3'd0;
    localparam logic [2:0] OFS_END  = 3'd1;
    localparam logic [2:0] OFS_HEAD = 3'd2;
    localparam logic [2:0] OFS_TAIL = 3'd3;
    localparam logic [2:0] OFS_STAT = 3'd4;
    localparam logic [2:0] OFS_ENA  = 3'd5;
    localparam logic [2:0] OFS_DROP = 3'd6;
endpackage

// File: rtl/rx_ring_fill.sv
module rx_ring_fill
    import rx_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned BUF_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  ring_end,
    input  logic [IDX_W-1:0]  tail,
    output logic [IDX_W-1:0]  head,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done_pulse,
    output logic              drop_pulse
);
    localparam int unsigned OFF_W  = $clog2(BUF_WORDS + 1);
    localparam int unsigned BPW    = DATA_W / 8;
    localparam int unsigned STRIDE = BUF_WORDS * BPW;
    localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(BUF_WORDS);

    typedef struct packed {
        pk_state_e         st;
        logic [OFF_W-1:0]  off;
        logic [IDX_W-1:0]  head;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } fill_t;

    fill_t q, d;
    logic [IDX_W:0]   head_inc;
    logic [IDX_W-1:0] head_nxt;

    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [ADDR_W-1:0] b,
        input logic [IDX_W-1:0]  h,
        input logic [OFF_W-1:0]  o
    );
        return b + ADDR_W'(h) * ADDR_W'(STRIDE) + ADDR_W'(o) * ADDR_W'(BPW);
    endfunction

    always_comb begin
        d          = q;
        d.we       = 1'b0;
        done_pulse = 1'b0;
        drop_pulse = 1'b0;
        head_inc   = {1'b0, q.head} + (IDX_W+1)'(1);
        head_nxt   = (head_inc >= {1'b0, ring_end}) ? '0 : head_inc[IDX_W-1:0];
        if (in_valid) begin
            unique case (q.st)
                PK_IDLE: begin
                    if (q.head != tail) begin
                        d.we    = 1'b1;
                        d.addr  = slot_addr(base, q.head, '0);
                        d.wdata = in_data;
                        if (in_last) begin
                            done_pulse = 1'b1;
                            d.head     = head_nxt;
                        end else begin
                            d.st  = PK_FILL;
                            d.off = OFF_W'(1);
                        end
                    end else begin
                        drop_pulse = 1'b1;
                        if (!in_last) d.st = PK_DROP;
                    end
                end
                PK_FILL: begin
                    if (q.off < OFF_LIMIT) begin
                        d.we    = 1'b1;
                        d.addr  = slot_addr(base, q.head, q.off);
                        d.wdata = in_data;
                        d.off   = q.off + OFF_W'(1);
                    end
                    if (in_last) begin
                        done_pulse = 1'b1;
                        d.head     = head_nxt;
                        d.st       = PK_IDLE;
                        d.off      = '0;
                    end
                end
                PK_DROP: begin
                    if (in_last) d.st = PK_IDLE;
                end
                default: d.st = PK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= PK_IDLE;
            q.off   <= '0;
            q.head  <= '0;
            q.we    <= 1'b0;
            q.addr  <= '0;
            q.wdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign head      = q.head;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;

    // R2: exhausted ring at packet start means no write
    a_r2_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q.st == PK_IDLE && q.head == tail) |=> !mem_we);
    // R10: a dropped packet stays silent
    a_r10_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PK_DROP) |=> !mem_we);
    // R4: offset never passes the buffer size
    a_r4_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.off <= OFF_LIMIT);
    // R5: head only steps by one or wraps to zero
    a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.head) |-> (q.head == '0 || q.head == IDX_W'($past(q.head) + 1'b1)));
endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
    import rx_ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0]  head,
    input  logic              done_pulse,
    input  logic              drop_pulse,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  ring_end,
    output logic [IDX_W-1:0]  tail,
    output logic              irq
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  rend;
        logic [IDX_W-1:0]  tail;
        logic              stat;
        logic              ena;
        logic [DROP_W-1:0] drops;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_we) begin
            unique case (reg_addr)
                OFS_BASE: d.base = reg_wdata;
                OFS_END:  d.rend = reg_wdata[IDX_W-1:0];
                OFS_TAIL: d.tail = reg_wdata[IDX_W-1:0];
                OFS_STAT: if (reg_wdata[0]) d.stat = 1'b0;
                OFS_ENA:  d.ena  = reg_wdata[0];
                default: ;
            endcase
        end
        if (done_pulse) d.stat = 1'b1;
        if (drop_pulse && q.drops != '1) d.drops = q.drops + DROP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.base  <= '0;
            q.rend  <= '0;
            q.tail  <= '0;
            q.stat  <= 1'b0;
            q.ena   <= 1'b0;
            q.drops <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_BASE: reg_rdata = q.base;
            OFS_END:  reg_rdata = ADDR_W'(q.rend);
            OFS_HEAD: reg_rdata = ADDR_W'(head);
            OFS_TAIL: reg_rdata = ADDR_W'(q.tail);
            OFS_STAT: reg_rdata = ADDR_W'(q.stat);
            OFS_ENA:  reg_rdata = ADDR_W'(q.ena);
            OFS_DROP: reg_rdata = ADDR_W'(q.drops);
            default:  reg_rdata = '0;
        endcase
    end

    assign base     = q.base;
    assign ring_end = q.rend;
    assign tail     = q.tail;
    assign irq      = q.stat & q.ena;

    // R7: a completion always leaves the flag set
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> q.stat);
    // R2: drop count never falls and holds at all ones
    a_r2_drop_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        q.drops >= $past(q.drops));
    a_r2_drop_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (q.drops == '1) |=> (q.drops == '1));
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
    import rx_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned BUF_WORDS = 8,
    parameter int unsigned DROP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);
    logic [ADDR_W-1:0] base_w;
    logic [IDX_W-1:0]  end_w;
    logic [IDX_W-1:0]  tail_w;
    logic [IDX_W-1:0]  head_w;
    logic              done_w;
    logic              drop_w;

    rx_ring_regs #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DROP_W(DROP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .head(head_w), .done_pulse(done_w), .drop_pulse(drop_w),
        .base(base_w), .ring_end(end_w), .tail(tail_w), .irq(irq)
    );

    rx_ring_fill #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BUF_WORDS(BUF_WORDS)
    ) u_fill (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .base(base_w), .ring_end(end_w), .tail(tail_w), .head(head_w),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done_pulse(done_w), .drop_pulse(drop_w)
    );

    // R8: interrupt never without a prior completion since reset
    a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(done_w) || $past(reg_we)));
endmodule

// File: tb/rx_ring_ctrl_bench.sv
module rx_ring_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int IDX_W = 4;
    localparam int BUF_WORDS = 8;
    localparam int DROP_W = 8;
    localparam int BPW = DATA_W / 8;
    localparam int DROP_MAX = (1 << DROP_W) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [ADDR_W-1:0] reg_wdata = 0;
    logic [ADDR_W-1:0] reg_rdata;
    logic in_valid = 0;
    logic [DATA_W-1:0] in_data = 0;
    logic in_last = 0;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic irq;

    int n_checks = 0;
    int n_errors = 0;

    int mbase = 0, mend = 0, mhead = 0, mtail = 0, mstat = 0, mena = 0, mdrops = 0;
    int mst = 0, moff = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .BUF_WORDS(BUF_WORDS), .DROP_W(DROP_W)
    ) u_rx_ring_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int h, input int o);
        return 32'(mbase + h * BUF_WORDS * BPW + o * BPW);
    endfunction

    function automatic int step_head(input int h);
        return (h + 1 >= mend) ? 0 : h + 1;
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic beat(input string tag, input logic [31:0] dat, input logic last);
        logic ewe;
        logic [31:0] ea;
        ewe = 0; ea = 0;
        case (mst)
            0: if (mhead != mtail) begin
                   ewe = 1; ea = exp_addr(mhead, 0);
                   if (last) begin mhead = step_head(mhead); mstat = 1; end
                   else begin mst = 1; moff = 1; end
               end else begin
                   if (mdrops < DROP_MAX) mdrops++;
                   if (!last) mst = 2;
               end
            1: begin
                   if (moff < BUF_WORDS) begin ewe = 1; ea = exp_addr(mhead, moff); moff++; end
                   if (last) begin mhead = step_head(mhead); mstat = 1; mst = 0; moff = 0; end
               end
            default: if (last) mst = 0;
        endcase
        @(negedge clk);
        in_valid = 1; in_data = dat; in_last = last;
        @(negedge clk);
        in_valid = 0; in_last = 0;
        chk({tag, " mem_we"}, 32'(mem_we), 32'(ewe));
        if (ewe) begin
            chk("R3 mem_addr", mem_addr, ea);
            chk("R3 mem_wdata", mem_wdata, dat);
        end
    endtask

    task automatic packet(input string tag, input int len);
        for (int i = 0; i < len; i++) beat(tag, $urandom, i == len - 1);
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        reg_read(3'd2, v); chk({tag, " R5 head"}, v, 32'(mhead));
        reg_read(3'd4, v); chk({tag, " R7 status"}, v, 32'(mstat));
        reg_read(3'd6, v); chk({tag, " R2 drops"}, v, 32'(mdrops));
        chk({tag, " R8 irq"}, 32'(irq), 32'(mstat & mena));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state, R9 map
        #1;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_we", 32'(mem_we), 0);
        check_state("R1");
        reg_read(3'd3, v); chk("R1 tail", v, 0);
        reg_read(3'd7, v); chk("R9 unused offset", v, 0);

        mbase = 32'h1000_0000; mend = 5;
        reg_write(3'd0, 32'(mbase));
        reg_write(3'd1, 32'(mend));
        reg_read(3'd0, v); chk("R9 base readback", v, 32'(mbase));
        reg_read(3'd1, v); chk("R9 end readback", v, 32'(mend));

        // R2 exhausted ring drops
        packet("R2 drop", 3);
        check_state("R2");

        // R6 doorbell gives slots 0..2
        reg_write(3'd3, 3); mtail = 3;
        reg_read(3'd3, v); chk("R6 tail readback", v, 3);
        packet("R6 first", 3);
        check_state("R6");
        // R8 enable
        reg_write(3'd5, 1); mena = 1;
        reg_read(3'd5, v); chk("R9 enable readback", v, 1);
        chk("R8 irq enabled", 32'(irq), 1);
        // R7 write 0 keeps, write 1 clears
        reg_write(3'd4, 0);
        check_state("R7 keep");
        reg_write(3'd4, 1); mstat = 0;
        check_state("R7 clear");

        // R4 truncation
        packet("R4 long", BUF_WORDS + 3);
        check_state("R4");
        // R5 head write ignored
        reg_write(3'd2, 0);
        check_state("R5 head write");
        packet("R5 fill", 1);
        check_state("R5 full");

        // R10 drop persists through a doorbell mid packet
        beat("R10 start", 32'hAAAA0001, 0);
        reg_write(3'd3, 0); mtail = 0;
        beat("R10 mid", 32'hAAAA0002, 0);
        beat("R10 end", 32'hAAAA0003, 1);
        check_state("R10");
        packet("R5 slot3", 2);
        packet("R5 wrap", 4);
        check_state("R5 wrap");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 2) begin
                mtail = $urandom_range(0, mend - 1);
                reg_write(3'd3, 32'(mtail));
            end else if (op == 2) begin
                mena = $urandom_range(0, 1);
                reg_write(3'd5, 32'(mena));
            end else if (op == 3) begin
                reg_write(3'd4, 1); mstat = 0;
            end else begin
                packet("R3 random", $urandom_range(1, BUF_WORDS + 2));
            end
            check_state("random");
        end

        // R2 saturation
        reg_write(3'd3, 32'(mhead)); mtail = mhead;
        for (int i = 0; i < DROP_MAX + 20; i++) packet("R2 sat", 1);
        check_state("R2 saturate");
        chk("R2 saturated value", 32'(mdrops), 32'(DROP_MAX));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule